// File: doc/BRIEF.md
# Trigger Queue Sleep Dispatcher

This block is the event-driven dispatch stage of one tile in a processing array. Incoming words arrive from four neighbour directions, each word tagged with one of three colours, and each (direction, colour) pair owns a single-word holding slot whose occupancy is the "ready" state of that channel. Trigger instructions append entries to a small queue; an entry holds a code-block address and one or two channels that must all be ready before the entry fires.

A sleep instruction makes the unit look at every queue entry each cycle. If any entry is ready the program counter jumps to that entry's block address; if none is, the counter stays on the sleep instruction and the check repeats next cycle. Entries are never removed, so a block that ends in sleep goes back to waiting on the same set of triggers. The unit also executes a receive-send instruction that, in a single cycle, takes the word from one channel slot, writes it to a register-file port and pushes it to an outbound channel.

Top module: `trig_sleep_dispatch`

## Requirements
- R1: After reset the program counter is 0, the overflow flag is 0, the queue is empty and every channel slot is empty, so `in_rdy` is 1 for every direction offering colour 0.
- R2: Directions are encoded north 0, west 1, south 2, east 3 and colours R 0, Y 1, B 2; the channel index is direction*3 + colour. A word is accepted on direction d when `in_vld[d]` and `in_rdy[d]` are both high; `in_rdy[d]` is low while the slot for that direction and offered colour is full, and always low for colour code 3. Readiness of one colour does not make another colour of the same direction ready.
- R3: Opcode 1 (one-channel trigger) appends an entry with target `op_target` and channel `op_src_chan`, and the program counter advances by one.
- R4: Opcode 2 (two-channel trigger) appends an entry with channels `op_src_chan` and `op_aux_chan`; such an entry fires only when both slots are full. Registration advances the program counter by one.
- R5: Opcode 3 (sleep) with no ready entry leaves the program counter unchanged and raises `stall` in that cycle.
- R6: Opcode 3 with a ready entry loads that entry's target into the program counter on the next clock edge, with `stall` low.
- R7: When several entries are ready in the same cycle, the one registered earliest (lowest queue position) wins.
- R8: Firing neither removes an entry nor consumes channel data; entries stay usable by later sleeps.
- R9: The queue holds 8 entries; a trigger registered when it is full is discarded, sets `trig_overflow`, which stays set until reset, and still advances the program counter.
- R10: Opcode 4 (receive-send) with a full source slot `op_src_chan` and a non-full destination `op_aux_chan` drives, in the same cycle, `rf_we`=1, `rf_addr`=`op_reg`, `rf_data` and `tx_data` equal to the slot word and `tx_vld`=1 with `tx_chan`=`op_aux_chan`; the slot is emptied and the program counter advances by one.
- R11: Opcode 4 with an empty source slot or with `tx_full` set for the destination performs no write, raises `stall`, keeps the program counter and keeps the source word.
- R12: Opcode 0 advances the program counter by one; with `op_valid` low, or for opcodes 5 to 7, the program counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| op_code | input | 3 | Operation code |
| op_target | input | PC_W | Block address for trigger registration |
| op_src_chan | input | 4 | First trigger channel, or receive-send source |
| op_aux_chan | input | 4 | Second trigger channel, or receive-send destination |
| op_reg | input | REG_AW | Register index written by receive-send |
| in_vld | input | 4 | Word offered per direction |
| in_col | input | 8 | Two-bit colour per direction |
| in_data | input | 4*DW | Word per direction |
| in_rdy | output | 4 | Slot for offered colour is free |
| tx_full | input | 12 | Outbound channel cannot take a word |
| tx_vld | output | 1 | Outbound word pushed this cycle |
| tx_chan | output | 4 | Outbound channel index |
| tx_data | output | DW | Outbound word |
| rf_we | output | 1 | Register write strobe |
| rf_addr | output | REG_AW | Register write index |
| rf_data | output | DW | Register write data |
| pc | output | PC_W | Program counter |
| stall | output | 1 | Sleep or receive-send is waiting |
| trig_overflow | output | 1 | Sticky queue overflow flag |

## Verification
The assertions assume that the instruction fields hold steady for a whole cycle and that `tx_full` reflects the outbound channel in the same cycle it is sampled; the bench changes every input only just after the rising edge, so these hold. They also assume channel indices beyond 11 are never treated as ready, and the stimulus only names indices 0 to 11 for triggers and receive-send. Arrivals are offered one per call and only to slots the bench knows to be empty, except where occupancy backpressure is itself under test.

// File: rtl/tqsd_pkg.sv
`timescale 1ns/1ps
package tqsd_pkg;

    localparam int NDIR  = 4;
    localparam int NCOL  = 3;
    localparam int NCH   = NDIR * NCOL;
    localparam int CH_W  = $clog2(NCH);
    localparam int COL_W = 2;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_TRIG_ONE  = 3'd1,
        OP_TRIG_TWO  = 3'd2,
        OP_SLEEP     = 3'd3,
        OP_RECV_SEND = 3'd4
    } op_e;

    function automatic logic chan_valid(input logic [CH_W-1:0] c);
        return c < CH_W'(NCH);
    endfunction

    function automatic logic chan_ready(input logic [NCH-1:0] full,
                                        input logic [CH_W-1:0] c);
        return chan_valid(c) && full[c];
    endfunction

endpackage

// File: rtl/tqsd_chan_slots.sv
`timescale 1ns/1ps
module tqsd_chan_slots import tqsd_pkg::*; #(
    parameter int DW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NDIR-1:0]       in_vld,
    input  logic [NDIR*COL_W-1:0] in_col,
    input  logic [NDIR*DW-1:0]    in_data,
    output logic [NDIR-1:0]       in_rdy,
    input  logic                  pop,
    input  logic [CH_W-1:0]       pop_chan,
    output logic [DW-1:0]         pop_data,
    output logic [NCH-1:0]        slot_full
);

    typedef struct packed {
        logic [NCH-1:0]         full;
        logic [NCH-1:0][DW-1:0] data;
    } slot_st_t;

    slot_st_t s_d, s_q;

    always_comb begin
        logic [COL_W-1:0] col;
        logic [CH_W-1:0]  idx;
        s_d = s_q;
        for (int d = 0; d < NDIR; d++) begin
            col = in_col[d*COL_W +: COL_W];
            idx = CH_W'(d * NCOL) + CH_W'(col);
            if (col < COL_W'(NCOL)) begin
                in_rdy[d] = !s_q.full[idx];
            end else begin
                in_rdy[d] = 1'b0;
            end
            if (in_vld[d] && in_rdy[d]) begin
                s_d.full[idx] = 1'b1;
                s_d.data[idx] = in_data[d*DW +: DW];
            end
        end
        if (pop && chan_valid(pop_chan)) begin
            s_d.full[pop_chan] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pop_data  = chan_valid(pop_chan) ? s_q.data[pop_chan] : '0;
    assign slot_full = s_q.full;

    // R11: a word is only taken from a slot that holds one
    a_r11_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (chan_valid(pop_chan) && s_q.full[pop_chan]));

    // R10: a taken word leaves its slot empty afterwards
    a_r10_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && chan_valid(pop_chan)) |=> !s_q.full[$past(pop_chan)]);

endmodule

// File: rtl/tqsd_trig_queue.sv
`timescale 1ns/1ps
module tqsd_trig_queue import tqsd_pkg::*; #(
    parameter int PC_W  = 12,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_en,
    input  logic            reg_two,
    input  logic [PC_W-1:0] reg_tgt,
    input  logic [CH_W-1:0] reg_ca,
    input  logic [CH_W-1:0] reg_cb,
    input  logic [NCH-1:0]  slot_full,
    output logic            hit,
    output logic [PC_W-1:0] hit_tgt,
    output logic            overflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic            two;
        logic [PC_W-1:0] tgt;
        logic [CH_W-1:0] ca;
        logic [CH_W-1:0] cb;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } tq_st_t;

    tq_st_t q_d, q_q;
    logic [DEPTH-1:0] ent_rdy;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign ent_rdy[i] = (CNT_W'(i) < q_q.cnt)
                          && chan_ready(slot_full, q_q.ent[i].ca)
                          && (!q_q.ent[i].two || chan_ready(slot_full, q_q.ent[i].cb));
    end

    always_comb begin
        hit     = 1'b0;
        hit_tgt = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ent_rdy[i]) begin
                hit     = 1'b1;
                hit_tgt = q_q.ent[i].tgt;
            end
        end
    end

    always_comb begin
        q_d = q_q;
        if (reg_en) begin
            if (q_q.cnt < CNT_W'(DEPTH)) begin
                q_d.ent[q_q.cnt[IDX_W-1:0]].two = reg_two;
                q_d.ent[q_q.cnt[IDX_W-1:0]].tgt = reg_tgt;
                q_d.ent[q_q.cnt[IDX_W-1:0]].ca  = reg_ca;
                q_d.ent[q_q.cnt[IDX_W-1:0]].cb  = reg_cb;
                q_d.cnt = q_q.cnt + 1'b1;
            end else begin
                q_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign overflow = q_q.ovf;

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CNT_W'(DEPTH));

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.ovf |=> q_q.ovf);

    a_r9_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && q_q.cnt == CNT_W'(DEPTH)) |=> (q_q.cnt == CNT_W'(DEPTH) && q_q.ovf));

    a_r3_entry_added: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && q_q.cnt < CNT_W'(DEPTH)) |=> q_q.cnt == $past(q_q.cnt) + 1'b1);

    // R8: firing never removes entries
    a_r8_entries_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |=> $stable(q_q.cnt));

endmodule

// File: rtl/trig_sleep_dispatch.sv
`timescale 1ns/1ps
module trig_sleep_dispatch import tqsd_pkg::*; #(
    parameter int DW     = 32,
    parameter int PC_W   = 12,
    parameter int QDEPTH = 8,
    parameter int REG_AW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [2:0]            op_code,
    input  logic [PC_W-1:0]       op_target,
    input  logic [CH_W-1:0]       op_src_chan,
    input  logic [CH_W-1:0]       op_aux_chan,
    input  logic [REG_AW-1:0]     op_reg,
    input  logic [NDIR-1:0]       in_vld,
    input  logic [NDIR*COL_W-1:0] in_col,
    input  logic [NDIR*DW-1:0]    in_data,
    output logic [NDIR-1:0]       in_rdy,
    input  logic [NCH-1:0]        tx_full,
    output logic                  tx_vld,
    output logic [CH_W-1:0]       tx_chan,
    output logic [DW-1:0]         tx_data,
    output logic                  rf_we,
    output logic [REG_AW-1:0]     rf_addr,
    output logic [DW-1:0]         rf_data,
    output logic [PC_W-1:0]       pc,
    output logic                  stall,
    output logic                  trig_overflow
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } core_st_t;

    core_st_t c_d, c_q;
    op_e      op;
    logic     is_trig, is_sleep, is_rs;
    logic     rs_go;
    logic     tq_hit;
    logic [PC_W-1:0] tq_hit_tgt;
    logic [NCH-1:0]  slot_full;
    logic [DW-1:0]   slot_word;

    assign op       = op_e'(op_code);
    assign is_trig  = op_valid && (op == OP_TRIG_ONE || op == OP_TRIG_TWO);
    assign is_sleep = op_valid && (op == OP_SLEEP);
    assign is_rs    = op_valid && (op == OP_RECV_SEND);
    assign rs_go    = is_rs
                   && chan_ready(slot_full, op_src_chan)
                   && chan_valid(op_aux_chan)
                   && !tx_full[op_aux_chan];

    tqsd_chan_slots #(.DW(DW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_col    (in_col),
        .in_data   (in_data),
        .in_rdy    (in_rdy),
        .pop       (rs_go),
        .pop_chan  (op_src_chan),
        .pop_data  (slot_word),
        .slot_full (slot_full)
    );

    tqsd_trig_queue #(.PC_W(PC_W), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (is_trig),
        .reg_two   (op == OP_TRIG_TWO),
        .reg_tgt   (op_target),
        .reg_ca    (op_src_chan),
        .reg_cb    (op_aux_chan),
        .slot_full (slot_full),
        .hit       (tq_hit),
        .hit_tgt   (tq_hit_tgt),
        .overflow  (trig_overflow)
    );

    always_comb begin
        c_d = c_q;
        if (op_valid) begin
            unique case (op)
                OP_IDLE, OP_TRIG_ONE, OP_TRIG_TWO: c_d.pc = c_q.pc + 1'b1;
                OP_SLEEP:     if (tq_hit) c_d.pc = tq_hit_tgt;
                OP_RECV_SEND: if (rs_go)  c_d.pc = c_q.pc + 1'b1;
                default:      c_d.pc = c_q.pc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pc      = c_q.pc;
    assign stall   = (is_sleep && !tq_hit) || (is_rs && !rs_go);
    assign rf_we   = rs_go;
    assign rf_addr = op_reg;
    assign rf_data = slot_word;
    assign tx_vld  = rs_go;
    assign tx_chan = op_aux_chan;
    assign tx_data = slot_word;

    a_r5_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sleep && !tq_hit) |=> $stable(pc));

    a_r6_wake_target: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sleep && tq_hit) |=> pc == $past(tq_hit_tgt));

    a_r11_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!rf_we && !tx_vld));

    a_r10_dst_room: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> (chan_valid(tx_chan) && !tx_full[tx_chan]));

    a_r12_no_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(pc));

endmodule

// File: tb/trig_sleep_dispatch_tb.sv
`timescale 1ns/1ps
module trig_sleep_dispatch_tb;

    localparam int DW = 32;
    localparam int PW = 12;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = '0;
    logic [PW-1:0] op_target = '0;
    logic [3:0]    op_src_chan = '0;
    logic [3:0]    op_aux_chan = '0;
    logic [RW-1:0] op_reg = '0;
    logic [3:0]    in_vld = '0;
    logic [7:0]    in_col = '0;
    logic [4*DW-1:0] in_data = '0;
    logic [3:0]    in_rdy;
    logic [11:0]   tx_full = '0;
    logic          tx_vld;
    logic [3:0]    tx_chan;
    logic [DW-1:0] tx_data;
    logic          rf_we;
    logic [RW-1:0] rf_addr;
    logic [DW-1:0] rf_data;
    logic [PW-1:0] pc;
    logic          stall;
    logic          trig_overflow;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic          s_stall, s_rf_we, s_tx_vld;
    logic [RW-1:0] s_rf_addr;
    logic [DW-1:0] s_rf_data, s_tx_data;
    logic [3:0]    s_tx_chan;

    trig_sleep_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_target(op_target), .op_src_chan(op_src_chan), .op_aux_chan(op_aux_chan),
        .op_reg(op_reg), .in_vld(in_vld), .in_col(in_col), .in_data(in_data),
        .in_rdy(in_rdy), .tx_full(tx_full), .tx_vld(tx_vld), .tx_chan(tx_chan),
        .tx_data(tx_data), .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .pc(pc), .stall(stall), .trig_overflow(trig_overflow)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] ch(input int dir, input int col);
        return 4'(dir * 3 + col);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; in_vld = '0; in_col = '0; tx_full = '0;
        @(posedge clk); @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic exec(input logic [2:0] code, input logic [PW-1:0] tgt,
                        input logic [3:0] src, input logic [3:0] aux,
                        input logic [RW-1:0] rg);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_target = tgt;
        op_src_chan = src; op_aux_chan = aux; op_reg = rg;
        #5;
        s_stall = stall; s_rf_we = rf_we; s_rf_addr = rf_addr; s_rf_data = rf_data;
        s_tx_vld = tx_vld; s_tx_chan = tx_chan; s_tx_data = tx_data;
        @(posedge clk);
        #1 op_valid = 1'b0;
    endtask

    task automatic arrive(input int dir, input int col, input logic [DW-1:0] w);
        @(negedge clk);
        in_vld[dir] = 1'b1;
        in_col[dir*2 +: 2] = 2'(col);
        in_data[dir*DW +: DW] = w;
        @(posedge clk);
        #1 in_vld[dir] = 1'b0;
    endtask

    task automatic rdy_for(input int dir, input int col, output logic r);
        @(negedge clk);
        in_col[dir*2 +: 2] = 2'(col);
        #5 r = in_rdy[dir];
    endtask

    task automatic t_reset_idle();
        logic r;
        do_reset();
        #5;
        chk_eq("R1 pc", 32'(pc), 0);
        chk_eq("R1 overflow", 32'(trig_overflow), 0);
        chk_eq("R1 stall", 32'(stall), 0);
        chk_eq("R1 in_rdy", 32'(in_rdy), 32'hf);
        exec(3'd0, 0, 0, 0, 0);
        chk_eq("R12 idle advances", 32'(pc), 1);
        @(negedge clk); @(negedge clk);
        chk_eq("R12 no op holds", 32'(pc), 1);
        exec(3'd7, 12'h3ff, 0, 0, 0);
        chk_eq("R12 reserved holds", 32'(pc), 1);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R5 empty queue stall", 32'(s_stall), 1);
        rdy_for(0, 0, r);
        chk_eq("R1 slot empty", 32'(r), 1);
    endtask

    task automatic t_colour();
        logic r;
        do_reset();
        arrive(1, 1, 32'h1234);
        rdy_for(1, 1, r); chk_eq("R2 full slot backpressure", 32'(r), 0);
        rdy_for(1, 0, r); chk_eq("R2 other colour free", 32'(r), 1);
        rdy_for(1, 3, r); chk_eq("R2 colour 3 rejected", 32'(r), 0);
        exec(3'd1, 12'h050, ch(1, 2), 0, 0);
        exec(3'd1, 12'h030, ch(1, 1), 0, 0);
        chk_eq("R3 registration advances", 32'(pc), 2);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R2 colour-separate wake", 32'(pc), 32'h030);
    endtask

    task automatic t_sleep_wake();
        logic r;
        do_reset();
        exec(3'd1, 12'h040, ch(0, 2), 0, 0);
        exec(3'd2, 12'h020, ch(1, 0), ch(0, 0), 0);
        chk_eq("R4 registration advances", 32'(pc), 2);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R5 sleep stall", 32'(s_stall), 1);
        chk_eq("R5 sleep pc held", 32'(pc), 2);
        arrive(0, 0, 32'h11);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R4 one of two not enough", 32'(pc), 2);
        arrive(1, 0, 32'h22);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R6 wake no stall", 32'(s_stall), 0);
        chk_eq("R6 two-channel wake", 32'(pc), 32'h020);
        arrive(0, 2, 32'hB0B0);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R7 lowest index wins", 32'(pc), 32'h040);
        exec(3'd4, 0, ch(0, 2), ch(2, 2), 4'd3);
        chk_eq("R10 rf_we", 32'(s_rf_we), 1);
        chk_eq("R10 rf_addr", 32'(s_rf_addr), 3);
        chk_eq("R10 rf_data", s_rf_data, 32'hB0B0);
        chk_eq("R10 tx_vld", 32'(s_tx_vld), 1);
        chk_eq("R10 tx_chan", 32'(s_tx_chan), 32'(ch(2, 2)));
        chk_eq("R10 tx_data", s_tx_data, 32'hB0B0);
        chk_eq("R10 pc advances", 32'(pc), 32'h041);
        rdy_for(0, 2, r);
        chk_eq("R10 slot emptied", 32'(r), 1);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R8 entry persists", 32'(pc), 32'h020);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 8; i++) exec(3'd1, 12'(16 + i), ch(3, 1), 0, 0);
        #5 chk_eq("R9 no overflow at depth", 32'(trig_overflow), 0);
        exec(3'd1, 12'h099, ch(0, 0), 0, 0);
        chk_eq("R9 overflow set", 32'(trig_overflow), 1);
        chk_eq("R9 pc advances", 32'(pc), 9);
        arrive(0, 0, 32'h5);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R9 dropped entry inert", 32'(pc), 9);
        arrive(3, 1, 32'h6);
        exec(3'd3, 0, 0, 0, 0);
        chk_eq("R9 kept entries fire", 32'(pc), 32'h010);
        chk_eq("R9 overflow sticky", 32'(trig_overflow), 1);
    endtask

    task automatic t_rs_stall();
        logic r;
        do_reset();
        exec(3'd4, 0, ch(3, 0), ch(0, 1), 4'd5);
        chk_eq("R11 empty src stall", 32'(s_stall), 1);
        chk_eq("R11 empty src no write", 32'(s_rf_we | s_tx_vld), 0);
        chk_eq("R11 empty src pc", 32'(pc), 0);
        arrive(3, 0, 32'hCAFE);
        tx_full = 12'(1) << ch(0, 1);
        exec(3'd4, 0, ch(3, 0), ch(0, 1), 4'd5);
        chk_eq("R11 full dst stall", 32'(s_stall), 1);
        chk_eq("R11 full dst no write", 32'(s_rf_we | s_tx_vld), 0);
        chk_eq("R11 full dst pc", 32'(pc), 0);
        rdy_for(3, 0, r);
        chk_eq("R11 word kept", 32'(r), 0);
        tx_full = '0;
        exec(3'd4, 0, ch(3, 0), ch(0, 1), 4'd5);
        chk_eq("R10 released write", 32'(s_rf_we), 1);
        chk_eq("R10 released data", s_rf_data, 32'hCAFE);
        chk_eq("R10 released pc", 32'(pc), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset_idle();
        t_colour();
        t_sleep_wake();
        t_overflow();
        t_rs_stall();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule